// File: doc/BRIEF.md
# Video Memory Access Slot Scheduler

This block lays out, one scanline at a time, how the memory bus of a tile-based video controller is shared. A divider turns the master clock into a slot strobe: one slot every four master cycles in the fast timing mode, every five in the slow one. A slot counter walks through the positions of the line and wraps at the line length of the selected drawing width. Each position is tagged as a refresh slot, an external slot (open to the CPU) or an internal slot (kept for display fetches). In the last master cycle of every external slot, a drain flag tells the CPU write queue that it may move one entry.

A one-bit state machine tracks whether the display is fetching (`WIN_FETCH`) or the CPU has the bus to itself (`WIN_FREE`). In `WIN_FETCH`, external slots are sparse: one every 16 slots, a back-to-back pair near the end of the line, and a 26-slot gap across the line boundary where horizontal sync falls. In `WIN_FREE`, or whenever the blank input is high, every slot that is not refresh is external. The *open* transition (`WIN_FETCH` to `WIN_FREE`) fires at the first slot of the back-to-back pair on the last active line. The *close* transition (`WIN_FREE` to `WIN_FETCH`) fires at the same slot on the line just before the first active line. Refresh positions are fixed in the line and do not depend on the state, on blanking or on line length changes made elsewhere.

Top module: `slot_scheduler`

## Requirements
- R1: `slot_en` is high for one master cycle out of every 4 when `wide_timing`=1, and one out of every 5 when `wide_timing`=0, independent of `wide_draw`; after reset is released the first pulse comes after 3 (or 4) rising edges.
- R2: `slot_pos` holds between strobes and advances by one on the edge that ends each `slot_en` cycle. It wraps to 0 after 209 when `wide_draw`=1 (210 slots) and after 170 when `wide_draw`=0 (171 slots).
- R3: `slot_type` is refresh (2'b10) exactly at positions 28+32k, for k<5 when `wide_draw`=1 and k<4 when `wide_draw`=0. This holds in both window states and under blanking.
- R4: In `WIN_FETCH` with `blank`=0, `slot_type` is external (2'b01) only at positions 4+16k (k<12 wide, k<10 narrow) and at the pair 187,188 (wide) or 148,149 (narrow). Every other non-refresh slot is internal (2'b00), giving 14 external slots per wide line and 11 per narrow line.
- R5: In `WIN_FETCH`, the largest distance between consecutive external slots is 26 slots, measured across the line wrap.
- R6: In `WIN_FREE`, or whenever `blank`=1, every non-refresh slot is external: 205 per wide line and 167 per narrow line.
- R7: Open and close transitions. In `WIN_FETCH`, a strobe at the first slot of the pair while `line_idx`=223 moves the state to `WIN_FREE`. In `WIN_FREE`, the same slot while `line_idx`=261 moves it to `WIN_FETCH`. The new pattern applies from the next slot, and the pair slot on any other line changes nothing.
- R8: `fifo_drain` is high exactly in the `slot_en` cycles whose slot is external, and low in every other cycle.
- R9: During and right after reset, `slot_pos`=0, `slot_en`=0, `fifo_drain`=0, and the state is `WIN_FREE`.
- R10: If `wide_draw` drops to 0 while `slot_pos` is beyond 170, the next strobe wraps `slot_pos` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_timing | input | 1 | 1: slot every 4 master cycles, 0: every 5 |
| wide_draw | input | 1 | 1: 40-cell line layout (210 slots), 0: 32-cell layout (171 slots) |
| blank | input | 1 | Forces the free pattern for the current slots |
| line_idx | input | 9 | Current scanline number |
| slot_en | output | 1 | High in the last master cycle of each slot |
| slot_type | output | 2 | 00 internal, 01 external, 10 refresh |
| slot_pos | output | 8 | Position of the current slot within the line |
| fifo_drain | output | 1 | CPU write queue may advance one entry |

## Verification
The hardest case to reach is the window transitions. Each one needs a specific line number to be present exactly when the counter reaches the first slot of the back-to-back pair. The close transition also cannot be seen until the machine has left the free state it enters at reset. The bench changes `line_idx` only at the last slot of each line. It walks line 261 to close the window, then fetch lines, then a non-transition line, then line 223, and checks every slot of every line against a model of the window. Blanked fetch lines and mode switches in the middle of a line are driven from the same line walker.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    typedef enum logic [1:0] {
        SLOT_INT = 2'b00,
        SLOT_EXT = 2'b01,
        SLOT_REF = 2'b10
    } slot_kind_t;

    typedef enum logic {
        WIN_FETCH = 1'b0,
        WIN_FREE  = 1'b1
    } win_state_t;

endpackage

// File: rtl/slot_clk_div.sv
module slot_clk_div #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fast,
    output logic tick
);
    localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CW      = $clog2(DIV_MAX);
    localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_last;

    assign cnt_last = sel_fast ? LAST_FAST : LAST_SLOW;
    // greater-or-equal keeps a rate change mid-count from skipping the wrap
    assign tick     = (cnt_q >= cnt_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/slot_pos_ctr.sv
module slot_pos_ctr #(
    parameter int SLOTS_WIDE   = 210,
    parameter int SLOTS_NARROW = 171,
    parameter int PW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wide,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] LAST_WIDE   = PW'(SLOTS_WIDE - 1);
    localparam logic [PW-1:0] LAST_NARROW = PW'(SLOTS_NARROW - 1);

    logic [PW-1:0] pos_last;
    logic          at_end;

    assign pos_last = wide ? LAST_WIDE : LAST_NARROW;
    assign at_end   = (pos >= pos_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (tick) begin
            if (at_end) begin
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/slot_classify.sv
module slot_classify
    import slot_sched_pkg::*;
#(
    parameter int PW           = 8,
    parameter int REF_BASE     = 28,
    parameter int REF_STRIDE   = 32,
    parameter int REF_CNT_W    = 5,
    parameter int REF_CNT_N    = 4,
    parameter int EXT_BASE     = 4,
    parameter int EXT_STRIDE   = 16,
    parameter int EXT_CNT_W    = 12,
    parameter int EXT_CNT_N    = 10,
    parameter int PAIR_WIDE    = 187,
    parameter int PAIR_NARROW  = 148
) (
    input  logic [PW-1:0] pos,
    input  logic          wide,
    input  logic          free_pattern,
    output slot_kind_t    kind
);
    localparam int REF_MAX = (REF_CNT_W > REF_CNT_N) ? REF_CNT_W : REF_CNT_N;
    localparam int EXT_MAX = (EXT_CNT_W > EXT_CNT_N) ? EXT_CNT_W : EXT_CNT_N;
    localparam logic [PW-1:0] PAIR_W0 = PW'(PAIR_WIDE);
    localparam logic [PW-1:0] PAIR_W1 = PW'(PAIR_WIDE + 1);
    localparam logic [PW-1:0] PAIR_N0 = PW'(PAIR_NARROW);
    localparam logic [PW-1:0] PAIR_N1 = PW'(PAIR_NARROW + 1);

    logic [REF_MAX-1:0] ref_hit;
    logic [EXT_MAX-1:0] grid_hit;
    logic               pair_hit;
    logic               is_ref;
    logic               is_grid_ext;

    // one comparator per refresh position; the mode gates off the unused ones
    for (genvar k = 0; k < REF_MAX; k++) begin : g_ref
        localparam logic [PW-1:0] REF_AT = PW'(REF_BASE + k * REF_STRIDE);
        localparam logic IN_W = (k < REF_CNT_W);
        localparam logic IN_N = (k < REF_CNT_N);
        assign ref_hit[k] = (wide ? IN_W : IN_N) && (pos == REF_AT);
    end

    // evenly spaced external slots of a fetching line
    for (genvar k = 0; k < EXT_MAX; k++) begin : g_ext
        localparam logic [PW-1:0] EXT_AT = PW'(EXT_BASE + k * EXT_STRIDE);
        localparam logic IN_W = (k < EXT_CNT_W);
        localparam logic IN_N = (k < EXT_CNT_N);
        assign grid_hit[k] = (wide ? IN_W : IN_N) && (pos == EXT_AT);
    end

    assign pair_hit    = wide ? ((pos == PAIR_W0) || (pos == PAIR_W1))
                              : ((pos == PAIR_N0) || (pos == PAIR_N1));
    assign is_ref      = |ref_hit;
    assign is_grid_ext = (|grid_hit) || pair_hit;

    always_comb begin
        if (is_ref) begin
            kind = SLOT_REF;
        end else if (free_pattern || is_grid_ext) begin
            kind = SLOT_EXT;
        end else begin
            kind = SLOT_INT;
        end
    end

endmodule

// File: rtl/slot_window_fsm.sv
module slot_window_fsm
    import slot_sched_pkg::*;
#(
    parameter int PW               = 8,
    parameter int LINE_W           = 9,
    parameter int PAIR_WIDE        = 187,
    parameter int PAIR_NARROW      = 148,
    parameter int LAST_ACTIVE_LINE = 223,
    parameter int PRE_FIRST_LINE   = 261
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wide,
    input  logic [PW-1:0]     pos,
    input  logic [LINE_W-1:0] line,
    output logic              free_win
);
    localparam logic [PW-1:0]     PAIR_W     = PW'(PAIR_WIDE);
    localparam logic [PW-1:0]     PAIR_N     = PW'(PAIR_NARROW);
    localparam logic [LINE_W-1:0] OPEN_LINE  = LINE_W'(LAST_ACTIVE_LINE);
    localparam logic [LINE_W-1:0] CLOSE_LINE = LINE_W'(PRE_FIRST_LINE);

    win_state_t state_q;
    win_state_t state_d;
    logic       at_pair;

    assign at_pair = tick && (pos == (wide ? PAIR_W : PAIR_N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_FETCH: if (at_pair && (line == OPEN_LINE))  state_d = WIN_FREE;
            WIN_FREE:  if (at_pair && (line == CLOSE_LINE)) state_d = WIN_FETCH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            WIN_FETCH: free_win = 1'b0;
            WIN_FREE:  free_win = 1'b1;
        endcase
    end

endmodule

// File: rtl/slot_scheduler.sv
module slot_scheduler
    import slot_sched_pkg::*;
#(
    parameter int DIV_WIDE         = 4,
    parameter int DIV_NARROW       = 5,
    parameter int SLOTS_WIDE       = 210,
    parameter int SLOTS_NARROW     = 171,
    parameter int REF_BASE         = 28,
    parameter int REF_STRIDE       = 32,
    parameter int REF_CNT_W        = 5,
    parameter int REF_CNT_N        = 4,
    parameter int EXT_BASE         = 4,
    parameter int EXT_STRIDE       = 16,
    parameter int EXT_CNT_W        = 12,
    parameter int EXT_CNT_N        = 10,
    parameter int PAIR_WIDE        = 187,
    parameter int PAIR_NARROW      = 148,
    parameter int LINE_W           = 9,
    parameter int LAST_ACTIVE_LINE = 223,
    parameter int PRE_FIRST_LINE   = 261,
    localparam int POS_W           = $clog2(SLOTS_WIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_timing,
    input  logic              wide_draw,
    input  logic              blank,
    input  logic [LINE_W-1:0] line_idx,
    output logic              slot_en,
    output logic [1:0]        slot_type,
    output logic [POS_W-1:0]  slot_pos,
    output logic              fifo_drain
);
    logic       free_win;
    slot_kind_t kind;

    slot_clk_div #(
        .DIV_FAST (DIV_WIDE),
        .DIV_SLOW (DIV_NARROW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_fast (wide_timing),
        .tick     (slot_en)
    );

    slot_pos_ctr #(
        .SLOTS_WIDE   (SLOTS_WIDE),
        .SLOTS_NARROW (SLOTS_NARROW),
        .PW           (POS_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slot_en),
        .wide  (wide_draw),
        .pos   (slot_pos)
    );

    slot_window_fsm #(
        .PW               (POS_W),
        .LINE_W           (LINE_W),
        .PAIR_WIDE        (PAIR_WIDE),
        .PAIR_NARROW      (PAIR_NARROW),
        .LAST_ACTIVE_LINE (LAST_ACTIVE_LINE),
        .PRE_FIRST_LINE   (PRE_FIRST_LINE)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slot_en),
        .wide     (wide_draw),
        .pos      (slot_pos),
        .line     (line_idx),
        .free_win (free_win)
    );

    slot_classify #(
        .PW          (POS_W),
        .REF_BASE    (REF_BASE),
        .REF_STRIDE  (REF_STRIDE),
        .REF_CNT_W   (REF_CNT_W),
        .REF_CNT_N   (REF_CNT_N),
        .EXT_BASE    (EXT_BASE),
        .EXT_STRIDE  (EXT_STRIDE),
        .EXT_CNT_W   (EXT_CNT_W),
        .EXT_CNT_N   (EXT_CNT_N),
        .PAIR_WIDE   (PAIR_WIDE),
        .PAIR_NARROW (PAIR_NARROW)
    ) u_cls (
        .pos          (slot_pos),
        .wide         (wide_draw),
        .free_pattern (free_win || blank),
        .kind         (kind)
    );

    assign slot_type  = kind;
    assign fifo_drain = slot_en && (kind == SLOT_EXT);

endmodule

// File: rtl/slot_sched_checker.sv
module slot_sched_checker #(
    parameter int PW           = 8,
    parameter int REF_BASE     = 28,
    parameter int NARROW_SLOTS = 171
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wide_draw,
    input logic          blank,
    input logic          slot_en,
    input logic [1:0]    slot_type,
    input logic [PW-1:0] slot_pos,
    input logic          fifo_drain
);
    localparam logic [PW-1:0] NARROW_LAST = PW'(NARROW_SLOTS - 1);
    localparam logic [PW-1:0] REF_FIRST   = PW'(REF_BASE);

    AST_EN_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> !slot_en); // R1

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && (slot_pos < NARROW_LAST)) |=> (slot_pos == $past(slot_pos) + 1'b1)); // R2

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(slot_pos)); // R2

    AST_REF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos == REF_FIRST) |-> (slot_type == 2'b10)); // R3

    AST_BLANK_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (slot_type != 2'b00)); // R6

    AST_DRAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drain |=> !fifo_drain); // R8

    AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && !wide_draw && (slot_pos >= NARROW_LAST)) |=> (slot_pos == '0)); // R10

endmodule

bind slot_scheduler slot_sched_checker #(
    .PW           (POS_W),
    .REF_BASE     (REF_BASE),
    .NARROW_SLOTS (SLOTS_NARROW)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_draw  (wide_draw),
    .blank      (blank),
    .slot_en    (slot_en),
    .slot_type  (slot_type),
    .slot_pos   (slot_pos),
    .fifo_drain (fifo_drain)
);

// File: tb/test_slot_scheduler.sv
module test_slot_scheduler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide_timing = 1'b1;
    logic       wide_draw = 1'b1;
    logic       blank = 1'b0;
    logic [8:0] line_idx = '0;
    logic       slot_en;
    logic [1:0] slot_type;
    logic [7:0] slot_pos;
    logic       fifo_drain;

    int  checks = 0;
    int  errors = 0;
    bit  model_free = 1'b1;

    always #4 clk = ~clk;

    slot_scheduler i_slot_scheduler (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_timing (wide_timing),
        .wide_draw   (wide_draw),
        .blank       (blank),
        .line_idx    (line_idx),
        .slot_en     (slot_en),
        .slot_type   (slot_type),
        .slot_pos    (slot_pos),
        .fifo_drain  (fifo_drain)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected slot kind from the requirement text (R3, R4, R6)
    function automatic logic [1:0] exp_type(input int pos, input bit wide, input bit free);
        int nref = wide ? 5 : 4;
        int ngrid = wide ? 12 : 10;
        int pair = wide ? 187 : 148;
        for (int k = 0; k < nref; k++) if (pos == 28 + 32 * k) return 2'b10;
        if (free) return 2'b01;
        for (int k = 0; k < ngrid; k++) if (pos == 4 + 16 * k) return 2'b01;
        if (pos == pair || pos == pair + 1) return 2'b01;
        return 2'b00;
    endfunction

    task automatic apply_reset(input bit wt, input bit wd);
        @(negedge clk);
        rst_n = 1'b0;
        wide_timing = wt;
        wide_draw = wd;
        blank = 1'b0;
        line_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_free = 1'b1;
    endtask

    // stop at the negedge of the last slot of a line
    task automatic align();
        int last = wide_draw ? 209 : 170;
        forever begin
            @(negedge clk);
            if (slot_en && int'(slot_pos) == last) break;
        end
    endtask

    task automatic run_line(input int line, input bit blk, input string req,
                            output int ext_cnt, output int max_gap);
        int total = wide_draw ? 210 : 171;
        int pair = wide_draw ? 187 : 148;
        int exp_pos = 0;
        int first = -1;
        int prev = -1;
        logic [1:0] et;
        line_idx = 9'(line);
        blank = blk;
        ext_cnt = 0;
        max_gap = 0;
        while (exp_pos < total) begin
            @(negedge clk);
            if (slot_en) begin
                chk(int'(slot_pos) == exp_pos, "R2", "slot position", int'(slot_pos), exp_pos);
                et = exp_type(exp_pos, wide_draw, model_free || blk);
                chk(slot_type == et, (et == 2'b10) ? "R3" : req,
                    $sformatf("type at slot %0d line %0d", exp_pos, line),
                    int'(slot_type), int'(et));
                chk(fifo_drain == (et == 2'b01), "R8", "drain at slot end",
                    int'(fifo_drain), int'(et == 2'b01));
                if (slot_type == 2'b01) begin
                    ext_cnt++;
                    if (prev >= 0 && exp_pos - prev > max_gap) max_gap = exp_pos - prev;
                    if (first < 0) first = exp_pos;
                    prev = exp_pos;
                end
                if (exp_pos == pair) begin
                    if (!model_free && line == 223) model_free = 1'b1;
                    else if (model_free && line == 261) model_free = 1'b0;
                end
                exp_pos++;
            end else begin
                chk(fifo_drain == 1'b0, "R8", "drain between strobes", int'(fifo_drain), 0);
            end
        end
        if (first >= 0 && first + total - prev > max_gap) max_gap = first + total - prev;
    endtask

    task automatic t_reset();
        apply_reset(1'b1, 1'b1);
        chk(slot_pos == 8'd0, "R9", "position after reset", int'(slot_pos), 0);
        chk(slot_en == 1'b0, "R9", "strobe after reset", int'(slot_en), 0);
        chk(fifo_drain == 1'b0, "R9", "drain after reset", int'(fifo_drain), 0);
        chk(slot_type == 2'b01, "R9", "slot 0 open after reset", int'(slot_type), 1);
    endtask

    task automatic t_divider(input bit wt, input bit wd);
        int d = wt ? 4 : 5;
        int n = 0;
        apply_reset(wt, wd);
        do begin
            @(negedge clk);
            n++;
        end while (!slot_en && n < 20);
        chk(n == d - 1, "R1", "edges to first strobe", n, d - 1);
        for (int p = 0; p < 3; p++) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!slot_en && n < 20);
            chk(n == d, "R1", "strobe period", n, d);
        end
    endtask

    task automatic t_free_line(input bit wd);
        int e;
        int g;
        apply_reset(wd, wd);
        align();
        run_line(5, 1'b0, "R6", e, g);
        chk(e == (wd ? 205 : 167), "R6", "externals on open line", e, wd ? 205 : 167);
    endtask

    task automatic t_window(input bit wd);
        int e;
        int g;
        apply_reset(wd, wd);
        align();
        run_line(261, 1'b0, "R7", e, g);
        run_line(0, 1'b0, "R4", e, g);
        chk(e == (wd ? 14 : 11), "R4", "externals on fetch line", e, wd ? 14 : 11);
        chk(g == 26, "R5", "largest external gap", g, 26);
        run_line(100, 1'b1, "R6", e, g);
        chk(e == (wd ? 205 : 167), "R6", "externals on blanked line", e, wd ? 205 : 167);
        run_line(101, 1'b0, "R7", e, g);
        chk(e == (wd ? 14 : 11), "R7", "pair on other line keeps fetch", e, wd ? 14 : 11);
        run_line(223, 1'b0, "R7", e, g);
        run_line(224, 1'b0, "R7", e, g);
        chk(e == (wd ? 205 : 167), "R7", "externals after open", e, wd ? 205 : 167);
    endtask

    task automatic t_width_switch();
        apply_reset(1'b1, 1'b1);
        forever begin
            @(negedge clk);
            if (slot_en && slot_pos == 8'd200) break;
        end
        wide_draw = 1'b0;
        @(negedge clk);
        chk(slot_pos == 8'd0, "R10", "wrap after width drop", int'(slot_pos), 0);
        forever begin
            @(negedge clk);
            if (slot_en) break;
        end
        @(negedge clk);
        chk(slot_pos == 8'd1, "R10", "count resumes after wrap", int'(slot_pos), 1);
    endtask

    initial begin
        t_reset();
        t_divider(1'b1, 1'b1);
        t_divider(1'b0, 1'b0);
        t_divider(1'b1, 1'b0);
        t_free_line(1'b1);
        t_free_line(1'b0);
        t_window(1'b1);
        t_window(1'b0);
        t_width_switch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule